// File: doc/BRIEF.md
# CPU-to-Printer Parallel Output Controller

This block connects a processor to a byte-wide printer. The processor sees two 8-bit registers behind a one-bit register select. One is a status word whose top bit reports that the controller can take a new byte. The other is a one-byte buffer that holds the character to print. A processor write to the buffer while the controller is idle stores the byte and clears the status word to zero. The controller then waits until the printer reports ready. At that point it puts the byte on the printer data lines and raises a transfer strobe for exactly one clock.

After the strobe, the controller waits for the printer to drop ready and then raise it again. Only then does it load the status word with the ready value 0x81. The processor can learn that the controller is ready in one of two ways, chosen by a mode input. In polling mode it reads the status word and tests bit 7. In interrupt mode an active-low request line is pulled low while the controller is idle.

Top module: `pout_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the status word becomes 0x81, the buffer becomes 0x00, `cpu_rdata` and `prn_data` become 0x00, `prn_strobe` goes low and `irq_n` goes high.
- R2: At a clock edge with `rw`=0, `cpu_rdata` is loaded with the selected register: `reg_sel`=0 selects the status word and `reg_sel`=1 selects the buffer. With `rw`=1, `cpu_rdata` holds its value.
- R3: At a clock edge with `rw`=1, `reg_sel`=1 and status bit 7 equal to 1, the buffer takes `cpu_wdata` and the status word becomes 0x00.
- R4: A buffer write while status bit 7 is 0 leaves the buffer unchanged. A write with `reg_sel`=0 leaves the status word unchanged.
- R5: After an accepted buffer write, `prn_strobe` goes high for exactly one cycle, after the first later edge at which `prn_ready` is 1. While `prn_strobe` is high, `prn_data` equals the buffered byte. No strobe appears while `prn_ready` stays 0.
- R6: After the strobe, the status word returns to 0x81 at the first edge at which `prn_ready` is 1, counted after an edge at which `prn_ready` was 0. Until then it stays 0x00.
- R7: In interrupt mode (`irq_mode`=1), `irq_n` at each edge takes the inverse of status bit 7 as it stood before that edge.
- R8: In polling mode (`irq_mode`=0), `irq_n` is driven high at every edge.
- R9: No second strobe occurs until the status word is back at 0x81 and a new buffer write has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rw | input | 1 | 1 = processor writes, 0 = processor reads |
| reg_sel | input | 1 | 0 = status word, 1 = buffer |
| cpu_wdata | input | 8 | Write data from the processor |
| cpu_rdata | output | 8 | Registered read data to the processor |
| irq_mode | input | 1 | 1 = interrupt mode, 0 = polling mode |
| irq_n | output | 1 | Active-low request for the next byte |
| prn_ready | input | 1 | Printer ready (1 = idle, 0 = busy) |
| prn_data | output | 8 | Byte presented to the printer |
| prn_strobe | output | 1 | One-cycle transfer request to the printer |

## Verification
The bench sends every byte value from 0 to 255 through a full transfer. Across the sweep it varies how long the printer holds off ready before the strobe (0 to 2 cycles) and how long it stays busy afterwards (1 to 3 cycles), and it alternates the interrupt and polling modes. It aims at four mistakes, each with a visible symptom:
- A strobe that fires without waiting for ready shows up early, while the printer is still busy.
- A controller that skips the busy phase reports 0x81 one cycle too soon.
- Writes made while busy, and writes to the status address, must leave no trace. A design that lets them through would overwrite the byte being printed or corrupt the status word on readback.
- The request line is compared against the mode on every pass. A design that pulls it low in polling mode, or with the wrong one-cycle lag, fails that comparison.

// File: rtl/pout_pkg.sv
package pout_pkg;

  typedef enum logic [1:0] {
    XS_IDLE   = 2'd0,
    XS_LOADED = 2'd1,
    XS_SENT   = 2'd2,
    XS_DRAIN  = 2'd3
  } xfer_state_e;

  // Ready word: top (idle) bit and bit 0 set.
  function automatic logic [31:0] ready_word_f(input int unsigned width);
    return (32'd1 << (width - 1)) | 32'd1;
  endfunction

  // Active-low request level for a given mode and idle flag.
  function automatic logic irq_level_f(input logic mode, input logic idle);
    return ~(mode & idle);
  endfunction

endpackage

// File: rtl/pout_xfer.sv
module pout_xfer
  import pout_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_buf,
  input  logic prn_ready,
  output logic accept,
  output logic fire,
  output logic done,
  output logic busy
);

  xfer_state_e state_q, state_d;

  assign accept = wr_buf && (state_q == XS_IDLE);
  assign fire   = (state_q == XS_LOADED) && prn_ready;
  assign done   = (state_q == XS_DRAIN) && prn_ready;
  assign busy   = (state_q != XS_IDLE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      XS_IDLE:   if (accept) state_d = XS_LOADED;
      XS_LOADED: if (fire) state_d = XS_SENT;
      XS_SENT:   if (!prn_ready) state_d = XS_DRAIN;
      XS_DRAIN:  if (done) state_d = XS_IDLE;
      default:   state_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= XS_IDLE;
    else     state_q <= state_d;
  end

  // R9: a new transfer needs a fresh acceptance, so fire never directly follows done
  p_no_refire_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !fire);

  // R5: fire is followed by the wait-for-busy phase, not another fire
  p_fire_once_r5: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);

endmodule

// File: rtl/pout_regs.sv
module pout_regs
  import pout_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              reg_sel,
  input  logic              wr_buf,
  input  logic              busy,
  input  logic              accept,
  input  logic              fire,
  input  logic              done,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [DATA_W-1:0] status_q,
  output logic [DATA_W-1:0] prn_data,
  output logic              prn_strobe
);

  localparam logic [DATA_W-1:0] READY_WORD = DATA_W'(ready_word_f(DATA_W));
  localparam int unsigned       IDLE_BIT   = DATA_W - 1;

  logic [DATA_W-1:0] buf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q   <= READY_WORD;
      buf_q      <= '0;
      cpu_rdata  <= '0;
      prn_data   <= '0;
      prn_strobe <= 1'b0;
    end else begin
      prn_strobe <= fire;
      if (accept) begin
        buf_q    <= cpu_wdata;
        status_q <= '0;
      end else if (done) begin
        status_q <= READY_WORD;
      end
      if (fire) prn_data <= buf_q;
      if (rd_en) cpu_rdata <= reg_sel ? buf_q : status_q;
    end
  end

  // R3: an accepted buffer write leaves the status word cleared
  p_write_clears_r3: assert property (@(posedge clk) disable iff (rst)
    accept |=> (status_q == '0));

  // R4: writes arriving while busy do not disturb the held byte
  p_busy_write_ignored_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_buf && busy) |=> $stable(buf_q));

  // R5: the strobed byte is the buffered byte
  p_strobe_data_r5: assert property (@(posedge clk) disable iff (rst)
    prn_strobe |-> (prn_data == buf_q));

  // R6: completion restores the ready word
  p_ready_word_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> (status_q == READY_WORD));

  // R6: the idle flag only rises through a completed transfer
  p_idle_rise_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(status_q[IDLE_BIT]) |-> $past(done));

endmodule

// File: rtl/pout_irq.sv
module pout_irq
  import pout_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic irq_mode,
  input  logic idle,
  output logic irq_n
);

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= irq_level_f(irq_mode, idle);
  end

  // R8: polling mode keeps the request released
  p_poll_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !irq_mode |=> irq_n);

  // R7: a busy controller never requests a byte
  p_busy_no_req_r7: assert property (@(posedge clk) disable iff (rst)
    !idle |=> irq_n);

endmodule

// File: rtl/pout_ctrl.sv
module pout_ctrl
  import pout_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rw,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              irq_mode,
  output logic              irq_n,
  input  logic              prn_ready,
  output logic [DATA_W-1:0] prn_data,
  output logic              prn_strobe
);

  localparam int unsigned IDLE_BIT = DATA_W - 1;

  logic              wr_buf, rd_en;
  logic              accept, fire, done, busy;
  logic [DATA_W-1:0] status_q;

  assign wr_buf = rw && reg_sel;
  assign rd_en  = !rw;

  pout_xfer u_xfer (
    .clk       (clk),
    .rst       (rst),
    .wr_buf    (wr_buf),
    .prn_ready (prn_ready),
    .accept    (accept),
    .fire      (fire),
    .done      (done),
    .busy      (busy)
  );

  pout_regs #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (rd_en),
    .reg_sel    (reg_sel),
    .wr_buf     (wr_buf),
    .busy       (busy),
    .accept     (accept),
    .fire       (fire),
    .done       (done),
    .cpu_wdata  (cpu_wdata),
    .cpu_rdata  (cpu_rdata),
    .status_q   (status_q),
    .prn_data   (prn_data),
    .prn_strobe (prn_strobe)
  );

  pout_irq u_irq (
    .clk      (clk),
    .rst      (rst),
    .irq_mode (irq_mode),
    .idle     (status_q[IDLE_BIT]),
    .irq_n    (irq_n)
  );

  // R5: the transfer request is exactly one cycle wide
  p_strobe_single_r5: assert property (@(posedge clk) disable iff (rst)
    prn_strobe |=> !prn_strobe);

  // R5: a strobe only follows a cycle in which the printer was ready
  p_strobe_needs_ready_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(prn_strobe) |-> $past(prn_ready));

  // R2: a read cycle of the status address returns the status word
  p_read_status_r2: assert property (@(posedge clk) disable iff (rst)
    (!rw && !reg_sel) |=> (cpu_rdata == $past(status_q)));

endmodule

// File: tb/tb_pout_ctrl.sv
module tb_pout_ctrl;

  localparam int W = 8;
  localparam logic [W-1:0] READY = 8'h81;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         rw = 1'b0;
  logic         reg_sel = 1'b0;
  logic [W-1:0] cpu_wdata = '0;
  logic [W-1:0] cpu_rdata;
  logic         irq_mode = 1'b0;
  logic         irq_n;
  logic         prn_ready = 1'b1;
  logic [W-1:0] prn_data;
  logic         prn_strobe;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  pout_ctrl #(.DATA_W(W)) dut (
    .clk        (clk),
    .rst        (rst),
    .rw         (rw),
    .reg_sel    (reg_sel),
    .cpu_wdata  (cpu_wdata),
    .cpu_rdata  (cpu_rdata),
    .irq_mode   (irq_mode),
    .irq_n      (irq_n),
    .prn_ready  (prn_ready),
    .prn_data   (prn_data),
    .prn_strobe (prn_strobe)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    tick(); tick();
    chk(prn_strobe == 1'b0, "R1 strobe", int'(prn_strobe), 0);
    chk(irq_n == 1'b1, "R1 irq_n", int'(irq_n), 1);
    chk(prn_data == 8'h00, "R1 prn_data", int'(prn_data), 0);
    chk(cpu_rdata == 8'h00, "R1 rdata", int'(cpu_rdata), 0);
    rst = 1'b0;
    rw = 1'b0; reg_sel = 1'b1;
    tick();
    chk(cpu_rdata == 8'h00, "R1 buffer cleared", int'(cpu_rdata), 0);
    reg_sel = 1'b0;
    tick();
    chk(cpu_rdata == READY, "R1 status after reset", int'(cpu_rdata), int'(READY));

    for (int v = 0; v < 256; v++) begin
      automatic logic [W-1:0] b = W'(v);
      automatic int  h = v % 3;
      automatic int  len = 1 + ((v / 4) % 3);
      automatic logic m = b[0];
      irq_mode = m;
      prn_ready = 1'b1;
      // R4: a write to the status address is ignored
      rw = 1'b1; reg_sel = 1'b0; cpu_wdata = b ^ 8'h5a;
      tick();
      rw = 1'b0; reg_sel = 1'b0;
      tick();
      chk(cpu_rdata == READY, "R4/R2 status read", int'(cpu_rdata), int'(READY));
      chk(irq_n == !m, "R7/R8 idle request", int'(irq_n), int'(!m));
      // R3: accepted buffer write (edge A)
      rw = 1'b1; reg_sel = 1'b1; cpu_wdata = b; prn_ready = (h == 0);
      tick();
      chk(prn_strobe == 1'b0, "R5 no strobe at accept", int'(prn_strobe), 0);
      // R5: hold ready low for h edges, with busy writes
      for (int k = 1; k <= h; k++) begin
        rw = 1'b1; reg_sel = 1'b1; cpu_wdata = ~b; prn_ready = 1'b0;
        tick();
        chk(prn_strobe == 1'b0, "R5 wait for ready", int'(prn_strobe), 0);
      end
      rw = 1'b0; reg_sel = 1'b1; prn_ready = 1'b1;
      tick();
      chk(prn_strobe == 1'b1, "R5 strobe", int'(prn_strobe), 1);
      chk(prn_data == b, "R5 data", int'(prn_data), int'(b));
      chk(cpu_rdata == b, "R4 buffer kept", int'(cpu_rdata), int'(b));
      // printer goes busy; another busy write
      rw = 1'b1; reg_sel = 1'b1; cpu_wdata = b + 8'd1; prn_ready = 1'b0;
      tick();
      chk(prn_strobe == 1'b0, "R5 one cycle", int'(prn_strobe), 0);
      chk(irq_n == 1'b1, "R7 busy no request", int'(irq_n), 1);
      for (int j = 2; j <= len; j++) begin
        rw = 1'b0; reg_sel = 1'b0; prn_ready = 1'b0;
        tick();
        chk(cpu_rdata == 8'h00, "R3/R6 status cleared", int'(cpu_rdata), 0);
        chk(prn_strobe == 1'b0, "R9 no refire", int'(prn_strobe), 0);
      end
      rw = 1'b0; reg_sel = 1'b1; prn_ready = 1'b1;
      tick();
      chk(cpu_rdata == b, "R4 busy write ignored", int'(cpu_rdata), int'(b));
      chk(prn_strobe == 1'b0, "R9 no strobe at done", int'(prn_strobe), 0);
      rw = 1'b0; reg_sel = 1'b0;
      tick();
      chk(cpu_rdata == READY, "R6 ready word", int'(cpu_rdata), int'(READY));
      chk(irq_n == !m, "R7/R8 request after done", int'(irq_n), int'(!m));
      chk(prn_strobe == 1'b0, "R9 quiet idle", int'(prn_strobe), 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule